// File: doc/BRIEF.md
# MII Receive Frame Status Monitor

This block sits beside a 4-bit MII receive interface and passively observes the data nibbles, the data-valid line and the receive-error line. For every frame it drops the preamble and start delimiter, pairs the nibbles into bytes, and runs a CRC-32 check over the bytes. It also picks up the two-byte length/type field and tracks error conditions while the frame runs.

When a frame ends, the block publishes a status word for one clock. A frame ends either when data-valid drops or when the receive watchdog cuts it short. The status word carries the byte count, a type/length classification, runt, receive-error, dribble-nibble, CRC-error, watchdog-truncation and clean-end flags. A downstream descriptor writer or statistics unit captures this word on the strobe. The watchdog limit is a parameter, and so is the width of the byte counter derived from it.

Top module: `mii_rx_status_mon`

## Requirements
- R1: After data-valid rises, the data starts with the nibble that follows a 0xD nibble which itself came directly after a 0x5 nibble. Every nibble before that point is discarded. Each byte is formed from two data nibbles, the first nibble giving bits 3:0, and `stat_bytes` reports the number of complete bytes.
- R2: `stat_type` is 1 exactly when the frame holds at least 14 complete bytes and the 16-bit value made of byte 12 (upper half) and byte 13 (lower half), counting from 0, is at least 0x0600. Otherwise it is 0. A value of 0x05FF therefore gives 0.
- R3: `stat_runt` is 1 when fewer than 14 complete bytes were received. In that case `stat_type` is 0.
- R4: `stat_rxerr` is 1 when the error input was high on any clock where data-valid was high, from the first valid clock of the frame up to its end or its truncation point.
- R5: `stat_crcerr` is 1 when the complete bytes, including the last four check bytes, do not pass the reflected CRC-32 check (polynomial 0xEDB88320, preset all ones, good residue 0xDEBB20E3). It is only ever 1 together with `stat_last`.
- R6: `stat_dribble` is 1 when a frame that ends normally carried an odd number of data nibbles. The trailing nibble counts neither as a byte nor in the CRC.
- R7: A data nibble that arrives while `WDOG_BYTES` bytes are already complete truncates the frame. The status then reports `stat_wdog`=1, `stat_bytes`=`WDOG_BYTES`, `stat_last`=0, `stat_crcerr`=0 and `stat_dribble`=0. The rest of that frame is ignored until data-valid goes low, and it produces no further status.
- R8: `stat_valid` is high for exactly one clock, after the first clock edge at which data-valid is sampled low in a frame, or after the truncating edge. A normal end reports `stat_last`=1. Every frame produces exactly one pulse.
- R9: While reset is asserted and after it, until the first frame ends, every status output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| stat_valid | output | 1 | One-clock status strobe |
| stat_type | output | 1 | Type-field frame (length/type at least 0x0600) |
| stat_runt | output | 1 | Fewer than 14 complete bytes |
| stat_rxerr | output | 1 | Receive error seen during the frame |
| stat_dribble | output | 1 | Odd number of data nibbles |
| stat_crcerr | output | 1 | Frame check sequence mismatch |
| stat_wdog | output | 1 | Frame truncated by the watchdog |
| stat_last | output | 1 | Frame ended normally on data-valid low |
| stat_bytes | output | $clog2(WDOG_BYTES+1) | Complete bytes received |

## Verification
The bench sends frames whose type field sits just above and just below the 0x0600 boundary. A comparator that is off by one would misclassify one of them. It also sends a 12-byte runt, whose leftover bytes could be taken as a type field, and frames with an extra nibble, where a design that counts nibbles badly would report an extra byte or miss the dribble. It places error pulses on the first and the last data nibble, where a narrow sampling window would miss them. It sends frames of exactly the limit and one nibble past it, and a frame far beyond it. These would expose a watchdog that fires a nibble early, flags CRC on a truncated frame, or emits a second strobe from the ignored tail.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

   localparam int          NIB_W       = 4;
   localparam int          BYTE_W      = 2 * NIB_W;
   localparam int          HDR_BYTES   = 14;
   localparam int          LT_HI_IDX   = 12;
   localparam int          LT_LO_IDX   = 13;
   localparam logic [3:0]  NIB_PRE     = 4'h5;
   localparam logic [3:0]  NIB_SFD_HI  = 4'hD;
   localparam logic [15:0] LT_TYPE_MIN = 16'h0600;
   localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
   localparam logic [31:0] CRC_PRESET  = 32'hFFFFFFFF;
   localparam logic [31:0] CRC_GOOD    = 32'hDEBB20E3;

   typedef enum logic [1:0] {
      AL_IDLE,
      AL_PRE,
      AL_DATA,
      AL_HOLD
   } align_st_e;

   function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                 input logic [BYTE_W-1:0] d);
      logic [31:0] c;
      c = c_in;
      for (int b = 0; b < BYTE_W; b++) begin
         if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_R;
         else             c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/mii_rx_align.sv
module mii_rx_align
   import mii_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NIB_W-1:0]  rxd,
   input  logic              rx_dv,
   input  logic              at_limit,
   output logic              start,
   output logic              busy,
   output logic              frame_end,
   output logic              trunc,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_val,
   output logic              phase_odd
);

   align_st_e        st_q, st_d;
   logic [NIB_W-1:0] prev_q;
   logic [NIB_W-1:0] low_q;
   logic             ph_q;
   logic             take;
   logic             sfd_hit;

   assign busy      = (st_q == AL_PRE) || (st_q == AL_DATA);
   assign start     = (st_q == AL_IDLE) && rx_dv;
   assign frame_end = busy && !rx_dv;
   assign trunc     = (st_q == AL_DATA) && rx_dv && at_limit;
   assign take      = (st_q == AL_DATA) && rx_dv && !at_limit;
   assign byte_stb  = take && ph_q;
   assign byte_val  = {rxd, low_q};
   assign phase_odd = ph_q;
   assign sfd_hit   = (st_q == AL_PRE) && rx_dv &&
                      (rxd == NIB_SFD_HI) && (prev_q == NIB_PRE);

   always_comb begin
      st_d = st_q;
      case (st_q)
         AL_IDLE: if (rx_dv) st_d = AL_PRE;
         AL_PRE:  if (!rx_dv) st_d = AL_IDLE;
                  else if (sfd_hit) st_d = AL_DATA;
         AL_DATA: if (!rx_dv) st_d = AL_IDLE;
                  else if (at_limit) st_d = AL_HOLD;
         AL_HOLD: if (!rx_dv) st_d = AL_IDLE;
         default: st_d = AL_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= AL_IDLE;
         prev_q <= '0;
         low_q  <= '0;
         ph_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == AL_IDLE || st_q == AL_PRE) prev_q <= rxd;
         if (start) ph_q <= 1'b0;
         if (take) begin
            if (!ph_q) low_q <= rxd;
            ph_q <= ~ph_q;
         end
      end
   end

endmodule

// File: rtl/mii_rx_crc32.sv
module mii_rx_crc32
   import mii_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              en,
   input  logic [BYTE_W-1:0] data,
   output logic              crc_ok
);

   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_q <= CRC_PRESET;
      else if (init) crc_q <= CRC_PRESET;
      else if (en)   crc_q <= crc_step_byte(crc_q, data);
   end

   assign crc_ok = (crc_q == CRC_GOOD);

endmodule

// File: rtl/mii_rx_wdog.sv
module mii_rx_wdog #(
   parameter int LIMIT = 2048,
   parameter int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             at_limit
);

   localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (inc && !at_limit)      cnt_q <= cnt_q + 1'b1;
   end

   assign count    = cnt_q;
   assign at_limit = (cnt_q == LIMIT_C);

endmodule

// File: rtl/mii_rx_status_mon.sv
module mii_rx_status_mon
   import mii_rx_pkg::*;
#(
   parameter int WDOG_BYTES = 2048,
   localparam int CNT_W = $clog2(WDOG_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       rxd,
   input  logic             rx_dv,
   input  logic             rx_er,
   output logic             stat_valid,
   output logic             stat_type,
   output logic             stat_runt,
   output logic             stat_rxerr,
   output logic             stat_dribble,
   output logic             stat_crcerr,
   output logic             stat_wdog,
   output logic             stat_last,
   output logic [CNT_W-1:0] stat_bytes
);

   localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR_BYTES);
   localparam logic [CNT_W-1:0] LT_HI_C = CNT_W'(LT_HI_IDX);
   localparam logic [CNT_W-1:0] LT_LO_C = CNT_W'(LT_LO_IDX);

   if (WDOG_BYTES < HDR_BYTES) begin : g_bad_limit
      $error("WDOG_BYTES must cover a full header");
   end
   if (NIB_W != 4) begin : g_bad_nib
      $error("nibble width must be 4");
   end

   logic              start, busy, frame_end, trunc, byte_stb, phase_odd;
   logic [BYTE_W-1:0] byte_val;
   logic              at_limit, crc_ok;
   logic [CNT_W-1:0]  cnt;
   logic [15:0]       lt_q;
   logic              er_q;

   mii_rx_align i_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .rxd       (rxd),
      .rx_dv     (rx_dv),
      .at_limit  (at_limit),
      .start     (start),
      .busy      (busy),
      .frame_end (frame_end),
      .trunc     (trunc),
      .byte_stb  (byte_stb),
      .byte_val  (byte_val),
      .phase_odd (phase_odd)
   );

   mii_rx_crc32 i_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (start),
      .en     (byte_stb),
      .data   (byte_val),
      .crc_ok (crc_ok)
   );

   mii_rx_wdog #(.LIMIT(WDOG_BYTES), .CNT_W(CNT_W)) i_wdog (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .inc      (byte_stb),
      .count    (cnt),
      .at_limit (at_limit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lt_q <= '0;
         er_q <= 1'b0;
      end else begin
         if (start)                         er_q <= rx_er;
         else if (busy && rx_dv && rx_er)   er_q <= 1'b1;
         if (start)                         lt_q <= '0;
         else if (byte_stb && cnt == LT_HI_C) lt_q[15:8] <= byte_val;
         else if (byte_stb && cnt == LT_LO_C) lt_q[7:0]  <= byte_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_valid   <= 1'b0;
         stat_type    <= 1'b0;
         stat_runt    <= 1'b0;
         stat_rxerr   <= 1'b0;
         stat_dribble <= 1'b0;
         stat_crcerr  <= 1'b0;
         stat_wdog    <= 1'b0;
         stat_last    <= 1'b0;
         stat_bytes   <= '0;
      end else begin
         stat_valid <= frame_end || trunc;
         if (frame_end || trunc) begin
            stat_bytes   <= cnt;
            stat_runt    <= (cnt < HDR_C);
            stat_type    <= (cnt >= HDR_C) && (lt_q >= LT_TYPE_MIN);
            stat_rxerr   <= er_q || (trunc && rx_er);
            stat_dribble <= frame_end && phase_odd;
            stat_crcerr  <= frame_end && !crc_ok;
            stat_wdog    <= trunc;
            stat_last    <= frame_end;
         end
      end
   end

endmodule

// File: rtl/mii_rx_status_chk.sv
module mii_rx_status_chk #(
   parameter int WDOG_BYTES = 2048,
   localparam int CNT_W = $clog2(WDOG_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_dv,
   input logic             stat_valid,
   input logic             stat_type,
   input logic             stat_runt,
   input logic             stat_dribble,
   input logic             stat_crcerr,
   input logic             stat_wdog,
   input logic             stat_last,
   input logic [CNT_W-1:0] stat_bytes
);

   localparam logic [CNT_W-1:0] LIM_C = CNT_W'(WDOG_BYTES);

   // R5: a CRC error is only reported on a clean end
   a_r5_crc_with_last: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_crcerr) |-> stat_last);

   // R3: type flag never accompanies a runt
   a_r3_runt_no_type: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_runt) |-> !stat_type);

   // R7: truncation reports a full count, no clean end, no dribble
   a_r7_wdog_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_wdog) |-> (!stat_last && !stat_dribble && stat_bytes == LIM_C));

   // R7: byte count never passes the limit
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> (stat_bytes <= LIM_C));

   // R8: strobe lasts one clock
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |=> !stat_valid);

   // R8: a clean end follows an edge with data-valid low
   a_r8_end_after_dv_low: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_last) |-> !$past(rx_dv));

   // R6: dribble only on a clean end
   a_r6_dribble_last: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_dribble) |-> stat_last);

endmodule

bind mii_rx_status_mon mii_rx_status_chk #(.WDOG_BYTES(WDOG_BYTES)) i_status_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_dv        (rx_dv),
   .stat_valid   (stat_valid),
   .stat_type    (stat_type),
   .stat_runt    (stat_runt),
   .stat_dribble (stat_dribble),
   .stat_crcerr  (stat_crcerr),
   .stat_wdog    (stat_wdog),
   .stat_last    (stat_last),
   .stat_bytes   (stat_bytes)
);

// File: tb/test_mii_rx_status_mon.sv
module test_mii_rx_status_mon;

   localparam int WD    = 2048;
   localparam int CW    = $clog2(WD + 1);
   localparam int MAXB  = 2200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    rxd = '0;
   logic          rx_dv = 1'b0;
   logic          rx_er = 1'b0;
   logic          stat_valid, stat_type, stat_runt, stat_rxerr;
   logic          stat_dribble, stat_crcerr, stat_wdog, stat_last;
   logic [CW-1:0] stat_bytes;

   int n_chk  = 0;
   int n_fail = 0;
   int n_pulse = 0;
   logic [7:0] fb [0:MAXB-1];

   // captured status
   int c_bytes;
   bit c_type, c_runt, c_rxerr, c_drib, c_crc, c_wdog, c_last;

   always #5 clk = ~clk;

   mii_rx_status_mon #(.WDOG_BYTES(WD)) i_mii_rx_status_mon (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
      .stat_valid(stat_valid), .stat_type(stat_type), .stat_runt(stat_runt),
      .stat_rxerr(stat_rxerr), .stat_dribble(stat_dribble),
      .stat_crcerr(stat_crcerr), .stat_wdog(stat_wdog),
      .stat_last(stat_last), .stat_bytes(stat_bytes)
   );

   always @(negedge clk) begin
      if (rst_n && stat_valid) begin
         n_pulse <= n_pulse + 1;
         c_bytes <= int'(stat_bytes);
         c_type  <= stat_type;
         c_runt  <= stat_runt;
         c_rxerr <= stat_rxerr;
         c_drib  <= stat_dribble;
         c_crc   <= stat_crcerr;
         c_wdog  <= stat_wdog;
         c_last  <= stat_last;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input int len);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) begin
         for (int b = 0; b < 8; b++) begin
            if (c[0] ^ fb[i][b]) c = (c >> 1) ^ 32'hEDB88320;
            else                 c = c >> 1;
         end
      end
      return c;
   endfunction

   task automatic drive(input logic [3:0] n, input bit dv, input bit er);
      @(negedge clk);
      rxd = n; rx_dv = dv; rx_er = er;
   endtask

   // er_idx: data nibble index carrying an error pulse, -1 for none
   task automatic send_frame(input string tag, input int nb, input bit extra,
                             input int er_idx, input bit bad, input logic [15:0] lt);
      logic [31:0] fcs;
      int tot, cnt, p0;
      bit wd, e_runt, e_type, e_drib, e_crc, e_er;
      for (int i = 0; i < nb; i++) fb[i] = 8'($urandom);
      if (nb >= 18) begin
         fb[12] = lt[15:8];
         fb[13] = lt[7:0];
      end
      if (nb <= 2 * WD) begin
         fcs = ~ref_crc(nb - 4);
         for (int k = 0; k < 4; k++) fb[nb - 4 + k] = fcs[8*k +: 8];
         if (bad) fb[nb - 1] = fb[nb - 1] ^ 8'h01;
      end
      p0 = n_pulse;
      for (int i = 0; i < 15; i++) drive(4'h5, 1'b1, 1'b0);
      drive(4'hD, 1'b1, 1'b0);
      for (int i = 0; i < nb; i++) begin
         drive(fb[i][3:0], 1'b1, (2*i) == er_idx);
         drive(fb[i][7:4], 1'b1, (2*i+1) == er_idx);
      end
      if (extra) drive(4'($urandom), 1'b1, (2*nb) == er_idx);
      drive(4'h0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      tot    = 2*nb + int'(extra);
      wd     = tot > 2*WD;
      cnt    = wd ? WD : nb;
      e_runt = cnt < 14;
      e_type = !e_runt && ({fb[12], fb[13]} >= 16'h0600);
      e_drib = !wd && extra;
      e_crc  = !wd && (ref_crc(cnt) != 32'hDEBB20E3);
      e_er   = (er_idx >= 0) && (er_idx < tot) && (er_idx <= 2*WD);
      chk("R8", {tag, " pulse count"}, n_pulse - p0, 1);
      chk("R1", {tag, " byte count"}, c_bytes, cnt);
      chk("R2", {tag, " type flag"}, int'(c_type), int'(e_type));
      chk("R3", {tag, " runt flag"}, int'(c_runt), int'(e_runt));
      chk("R4", {tag, " rx error"}, int'(c_rxerr), int'(e_er));
      chk("R5", {tag, " crc error"}, int'(c_crc), int'(e_crc));
      chk("R6", {tag, " dribble"}, int'(c_drib), int'(e_drib));
      chk("R7", {tag, " watchdog"}, int'(c_wdog), int'(wd));
      chk("R8", {tag, " last"}, int'(c_last), int'(!wd));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R9", "valid in reset", int'(stat_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9", "valid after reset", int'(stat_valid), 0);
      chk("R9", "flags after reset",
          int'({stat_type, stat_runt, stat_rxerr, stat_dribble, stat_crcerr, stat_wdog, stat_last}), 0);
      chk("R9", "bytes after reset", int'(stat_bytes), 0);

      send_frame("good",     64, 1'b0, -1, 1'b0, 16'h0800);
      send_frame("badcrc",   64, 1'b0, -1, 1'b1, 16'h0800);
      send_frame("odd",      40, 1'b1, -1, 1'b0, 16'h0040);
      send_frame("er_first", 30, 1'b0,  0, 1'b0, 16'h0700);
      send_frame("er_last",  30, 1'b1, 60, 1'b0, 16'h0700);
      send_frame("lt0600",   46, 1'b0, -1, 1'b0, 16'h0600);
      send_frame("lt05ff",   46, 1'b0, -1, 1'b0, 16'h05FF);
      send_frame("runt12",   12, 1'b0, -1, 1'b0, 16'h0000);
      send_frame("at_limit", WD, 1'b0, -1, 1'b0, 16'h0800);
      send_frame("limit_p1", WD, 1'b1, 2*WD, 1'b0, 16'h0800);
      send_frame("overlong", 2100, 1'b0, 3000, 1'b0, 16'h0800);
      send_frame("after_wd", 20, 1'b0, -1, 1'b0, 16'h0600);

      for (int f = 0; f < 24; f++) begin
         int nb, er;
         bit ex, bd;
         logic [15:0] lt;
         nb = 18 + int'($urandom % 60);
         ex = ($urandom % 4) == 0;
         er = (($urandom % 4) == 0) ? int'($urandom % (2*nb)) : -1;
         bd = ($urandom % 3) == 0;
         lt = ($urandom % 2) ? 16'(16'h0600 + $urandom % 16'h0800) : 16'($urandom % 16'h0600);
         send_frame("random", nb, ex, er, bd, lt);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule